// File: doc/BRIEF.md
# SPI-mode memory card command engine

This block runs one complete command transaction against a memory card attached over SPI. The host side presents a 48-bit command frame and a one-cycle start request. The engine pulls chip select low and shifts the six command bytes out most significant bit first. It then keeps clocking all-ones filler bytes and scans the returned bytes for the start of the card's response.

Once the response is found, the engine captures one or two response bytes. For busy-type commands it keeps polling until the card stops holding its data-out line low, or until a programmable poll limit runs out. It then clocks one more filler byte with the card still selected, raises chip select and pulses done. The response bytes and the two error flags remain valid until the next start.

The SPI clock is derived from the system clock by a fixed divider. The bus runs in mode 0: the clock idles low, the card's output is sampled on the rising edge, and the host output changes on the falling edge.

Top module: `mcard_spi_cmd`

## Requirements
- R1: After reset and between transactions, cs_no is 1, sclk_o is 0, mosi_o is 1 and done_o is 0.
- R2: A start_i pulse while idle lowers cs_no and sends cmd_i as six bytes, cmd_i[47:40] first, each byte MSB first, in SPI mode 0. Each sclk_o half period lasts CLK_DIV system clocks, and mosi_o never changes on a rising sclk_o edge.
- R3: After the six command bytes, every byte shifted out on mosi_o is 0xFF, and mosi_o is 1 while cs_no is high.
- R4: Among the bytes received after the command, the first one with bit 7 equal to 0 is the first response byte and appears in resp_o[7:0]. At most RESP_POLL (8) received bytes are inspected.
- R5: If none of the RESP_POLL inspected bytes has bit 7 equal to 0, timeout_o is 1, resp_o is 0 and no busy polling takes place.
- R6: With resp2_i = 1, the byte received right after the first response byte goes to resp_o[15:8]. With resp2_i = 0, resp_o[15:8] is 0.
- R7: With busy_i = 1, the engine polls further bytes after the response. A received byte of 0x00 means busy, and any other value, including a partial release such as 0x01, ends polling.
- R8: If busy_max_i (1 or more) polled bytes in a row are all 0x00, busy_to_o is 1 and polling stops at that byte.
- R9: After the last scanned byte, exactly one further 0xFF byte (8 clocks) is sent with cs_no low. cs_no then rises in the same cycle as a one-cycle done_o pulse.
- R10: start_i pulses that arrive while a transaction is running are ignored. The number of bytes clocked and the captured inputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| cmd_i | input | 48 | Command frame, first byte in bits 47:40 |
| resp2_i | input | 1 | 1 = two-byte response |
| busy_i | input | 1 | 1 = busy-type command, poll after the response |
| busy_max_i | input | BMAX_W | Maximum number of busy bytes polled |
| done_o | output | 1 | One-cycle completion pulse |
| resp_o | output | 16 | Response, first byte in bits 7:0 |
| timeout_o | output | 1 | No response start was found |
| busy_to_o | output | 1 | Busy poll limit was reached |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Data to the card |
| miso_i | input | 1 | Data from the card |

## Verification
The hardest situations to reach are the edges of the two search windows. One is a response that arrives on the last permitted filler byte compared with one byte too late. The other is a busy period that ends on the last allowed poll compared with one that reaches the limit. The bench models the card as a byte script indexed by the count of falling sclk edges since chip select fell, so it can place the response after any number of filler bytes and insert any number of 0x00 busy bytes exactly. Directed scripts hit each boundary on both sides, including a partial busy release. Randomised scripts spread the response delay across and past the limit.

// File: rtl/mcard_pkg.sv
package mcard_pkg;
  localparam int CMD_BYTES = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_RESP2,
    ST_BUSY,
    ST_TRAIL
  } mcard_state_e;
endpackage

// File: rtl/mcard_tick_gen.sv
module mcard_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mcard_byte_shift.sv
module mcard_byte_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       active_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  logic       active_q, sclk_q, done_q;
  logic [2:0] bit_q;
  logic [7:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= 8'hFF;
      rx_q     <= 8'hFF;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_i;
          bit_q    <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (tick_i) begin
        if (!sclk_q) begin
          // rising edge: sample card output
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          // falling edge: advance to next bit
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b1};
          end
        end
      end
    end
  end

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = active_q ? tx_q[7] : 1'b1;
  assign rx_o     = rx_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mcard_spi_cmd.sv
module mcard_spi_cmd
  import mcard_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int RESP_POLL = 8,
  parameter int BMAX_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [47:0]       cmd_i,
  input  logic              resp2_i,
  input  logic              busy_i,
  input  logic [BMAX_W-1:0] busy_max_i,
  output logic              done_o,
  output logic [15:0]       resp_o,
  output logic              timeout_o,
  output logic              busy_to_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int PW    = $clog2(RESP_POLL + 1);
  localparam int CNT_W = (BMAX_W > PW) ? BMAX_W : PW;

  mcard_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    cnt_inc;
  logic [47:0]       cmd_q, cmd_sh;
  logic              resp2_q, busy_q;
  logic [BMAX_W-1:0] bmax_q;
  logic              go_q, cs_nq, done_q, tmo_q, bto_q;
  logic [15:0]       resp_q;
  logic [7:0]        tx_byte, rx_byte;
  logic              sh_active, sh_done, tick;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign cmd_sh  = cmd_q << {cnt_q[2:0], 3'b000};
  assign tx_byte = (state_q == ST_CMD) ? cmd_sh[47:40] : 8'hFF;

  mcard_tick_gen #(.DIV(CLK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sh_active),
    .tick_o (tick)
  );

  mcard_byte_shift i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_q),
    .tx_i     (tx_byte),
    .tick_i   (tick),
    .miso_i   (miso_i),
    .active_o (sh_active),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .rx_o     (rx_byte),
    .done_o   (sh_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      resp2_q <= 1'b0;
      busy_q  <= 1'b0;
      bmax_q  <= '0;
      go_q    <= 1'b0;
      cs_nq   <= 1'b1;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      bto_q   <= 1'b0;
      resp_q  <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cmd_q   <= cmd_i;
          resp2_q <= resp2_i;
          busy_q  <= busy_i;
          bmax_q  <= busy_max_i;
          cs_nq   <= 1'b0;
          go_q    <= 1'b1;
          cnt_q   <= '0;
          tmo_q   <= 1'b0;
          bto_q   <= 1'b0;
          resp_q  <= '0;
          state_q <= ST_CMD;
        end
        ST_CMD: if (sh_done) begin
          go_q <= 1'b1;
          if (cnt_q == CNT_W'(CMD_BYTES - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_WAIT;
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end
        ST_WAIT: if (sh_done) begin
          go_q <= 1'b1;
          if (!rx_byte[7]) begin
            resp_q[7:0] <= rx_byte;
            cnt_q       <= '0;
            state_q     <= resp2_q ? ST_RESP2 : (busy_q ? ST_BUSY : ST_TRAIL);
          end else if (cnt_q == CNT_W'(RESP_POLL - 1)) begin
            tmo_q   <= 1'b1;
            state_q <= ST_TRAIL;
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end
        ST_RESP2: if (sh_done) begin
          go_q         <= 1'b1;
          resp_q[15:8] <= rx_byte;
          cnt_q        <= '0;
          state_q      <= busy_q ? ST_BUSY : ST_TRAIL;
        end
        ST_BUSY: if (sh_done) begin
          go_q <= 1'b1;
          if (rx_byte != 8'h00) begin
            state_q <= ST_TRAIL;
          end else if (cnt_inc >= {{(CNT_W+1-BMAX_W){1'b0}}, bmax_q}) begin
            bto_q   <= 1'b1;
            state_q <= ST_TRAIL;
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end
        ST_TRAIL: if (sh_done) begin
          cs_nq   <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = cs_nq;
  assign done_o    = done_q;
  assign resp_o    = resp_q;
  assign timeout_o = tmo_q;
  assign busy_to_o = bto_q;
endmodule

// File: rtl/mcard_spi_cmd_chk.sv
module mcard_spi_cmd_chk #(
  parameter int BMAX_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [47:0]       cmd_i,
  input logic              resp2_i,
  input logic              busy_i,
  input logic [BMAX_W-1:0] busy_max_i,
  input logic              done_o,
  input logic [15:0]       resp_o,
  input logic              timeout_o,
  input logic              busy_to_o,
  input logic              sclk_o,
  input logic              cs_no,
  input logic              mosi_o,
  input logic              miso_i
);
  a_r1_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r2_mosi_stable_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
  a_r2_select_with_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sclk_o);
  a_r3_mosi_high_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> mosi_o);
  a_r5_timeout_no_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (resp_o == 16'h0000 && !busy_to_o));
  a_r9_done_with_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no);
endmodule

bind mcard_spi_cmd mcard_spi_cmd_chk #(.BMAX_W(BMAX_W)) i_chk (.*);

// File: tb/test_mcard_spi_cmd.sv
module test_mcard_spi_cmd;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [47:0]   cmd = '0;
  logic          resp2 = 1'b0, busy = 1'b0;
  logic [BW-1:0] bmax = '0;
  logic          done, tmo, bto, sclk, cs_n, mosi;
  logic [15:0]   resp;
  logic          miso;

  int tests = 0, fails = 0;
  bit hung = 0;

  logic [7:0] card_bytes [0:127];
  logic [7:0] mosi_log   [0:127];
  int bitcnt = 0;
  int last_bits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcard_spi_cmd i_mcard_spi_cmd (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd),
    .resp2_i(resp2), .busy_i(busy), .busy_max_i(bmax),
    .done_o(done), .resp_o(resp), .timeout_o(tmo), .busy_to_o(bto),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // card model: output changes on falling sclk, count resets on deselect
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      if (bitcnt != 0) last_bits = bitcnt;
      bitcnt = 0;
    end else begin
      bitcnt = bitcnt + 1;
    end
  end

  always @(posedge sclk) begin
    if (!cs_n && bitcnt < 1024) mosi_log[bitcnt/8][7 - (bitcnt % 8)] = mosi;
  end

  always_comb begin
    miso = 1'b1;
    if (!cs_n && bitcnt < 1024) miso = card_bytes[bitcnt/8][7 - (bitcnt % 8)];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_bytes(input int d, input bit r2, input bit bz,
                                   input int b, input int bm);
    int n;
    n = 6;
    if (d >= 8) return n + 8 + 1;
    n += d + 1;
    if (r2) n += 1;
    if (bz) n += (b < bm) ? b + 1 : bm;
    return n + 1;
  endfunction

  task automatic run_txn(input logic [47:0] c, input int d, input logic [7:0] r1,
                         input logic [7:0] r2b, input bit r2, input bit bz,
                         input int b, input int bm, input logic [7:0] rel,
                         input bit mid_start);
    int idx, nexp, cyc;
    bit mok;
    logic [15:0] eresp;
    if (hung) return;
    for (int i = 0; i < 128; i++) begin card_bytes[i] = 8'hFF; mosi_log[i] = 8'h00; end
    idx = 6 + d;
    if (d < 8) begin
      card_bytes[idx] = r1; idx++;
      if (r2) begin card_bytes[idx] = r2b; idx++; end
      if (bz) begin
        for (int i = 0; i < b; i++) begin card_bytes[idx] = 8'h00; idx++; end
        card_bytes[idx] = rel;
      end
    end
    @(negedge clk);
    cmd = c; resp2 = r2; busy = bz; bmax = BW'(bm); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (mid_start && cyc == 200) begin
        start = 1'b1; cmd = ~c; resp2 = ~r2; busy = ~bz; bmax = '0;
      end else start = 1'b0;
    end
    if (!done) begin
      hung = 1;
      check(0, "R9", "watchdog, done_o never seen", 0, 1);
      return;
    end
    nexp = exp_bytes(d, r2, bz, b, bm);
    eresp = '0;
    if (d < 8) begin eresp[7:0] = r1; if (r2) eresp[15:8] = r2b; end
    check(cs_n == 1'b1 && sclk == 1'b0, "R9", "deselected at done", {cs_n, sclk}, 2'b10);
    check(last_bits == 8 * nexp, mid_start ? "R10" : "R9", "clocks in transaction",
          last_bits, 8 * nexp);
    check(resp == eresp, (d < 8) ? (r2 ? "R6" : "R4") : "R5", "resp_o", resp, eresp);
    check(tmo == (d >= 8), "R5", "timeout_o", tmo, d >= 8);
    check(bto == (d < 8 && bz && b >= bm), "R8", "busy_to_o", bto, (d < 8 && bz && b >= bm));
    mok = 1;
    for (int i = 0; i < 6; i++) if (mosi_log[i] !== c[47 - 8*i -: 8]) mok = 0;
    check(mok, "R2", "command bytes on mosi", mosi_log[0], c[47:40]);
    mok = 1;
    for (int i = 6; i < nexp && i < 128; i++) if (mosi_log[i] !== 8'hFF) mok = 0;
    check(mok, "R3", "filler bytes all ones", mok, 1);
    // R7: release byte ends polling when bz and b < bm (covered by clock count above)
  endtask

  initial begin
    int d, b, bm;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && mosi && !done, "R1", "reset outputs",
          {cs_n, sclk, mosi, done}, 4'b1010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && !sclk && mosi && !done, "R1", "idle after reset",
          {cs_n, sclk, mosi, done}, 4'b1010);

    run_txn(48'h40_00_00_00_00_95, 0, 8'h01, 8'h00, 0, 0, 0, 1, 8'hFF, 0); // R4 immediate
    run_txn(48'h4D_12_34_56_78_9B, 7, 8'h7F, 8'h00, 0, 0, 0, 1, 8'hFF, 0); // R4 last filler
    run_txn(48'h51_A5_5A_C3_3C_01, 8, 8'h00, 8'h00, 0, 1, 3, 5, 8'hFF, 0); // R5 one too late
    run_txn(48'h7A_00_FF_00_FF_77, 2, 8'h00, 8'hC4, 1, 0, 0, 1, 8'hFF, 0); // R6
    run_txn(48'h5C_01_02_03_04_05, 1, 8'h00, 8'h00, 0, 1, 0, 4, 8'hFF, 0); // R7 no busy
    run_txn(48'h5C_11_22_33_44_55, 3, 8'h00, 8'h00, 0, 1, 4, 5, 8'hFF, 0); // R7 release on last poll
    run_txn(48'h5C_66_77_88_99_AA, 0, 8'h00, 8'h00, 0, 1, 5, 5, 8'hFF, 0); // R8 limit reached
    run_txn(48'h5C_BB_CC_DD_EE_FF, 4, 8'h04, 8'h00, 1, 1, 6, 9, 8'h01, 0); // R7 partial release
    run_txn(48'h4C_0F_1E_2D_3C_4B, 1, 8'h00, 8'h00, 0, 1, 2, 1, 8'hFF, 0); // R8 max of 1
    run_txn(48'h42_99_88_77_66_55, 5, 8'h05, 8'h3E, 1, 1, 3, 6, 8'hFF, 1); // R10 mid start

    for (int n = 0; n < 25; n++) begin
      d  = $urandom % 10;
      b  = $urandom % 12;
      bm = 1 + $urandom % 10;
      run_txn({8'h40 | 8'($urandom % 64), 32'($urandom), 8'($urandom)}, d,
              8'($urandom) & 8'h7F, 8'($urandom), 1'($urandom), 1'($urandom),
              b, bm, 8'($urandom % 255) + 8'h01, 0);
    end

    @(negedge clk);
    check(cs_n && !sclk && mosi, "R3", "idle lines at end", {cs_n, sclk, mosi}, 3'b101);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule